// File: doc/BRIEF.md
# I2C Multi-Address Slave Recognizer

This block listens to an I2C clock and data line pair as a passive observer. It brings both lines into the system clock domain and detects bus START, repeated START and STOP conditions. After each START it shifts in the first byte and decides whether the local device is being addressed. Four programmable 7-bit slave addresses are checked in parallel. Each address has its own per-bit don't-care mask and its own general-call enable.

Every byte received inside a transfer is copied into a read-only data buffer once its acknowledge bit has been clocked. The address decision is reported as a single-cycle pulse. Alongside the pulse come the index of the matching address slot, a general-call flag and the received direction bit. The slot addresses and masks are loaded through a plain synchronous write port. The block does not drive the bus. ACK generation, clock stretching and master operation belong to neighbouring logic that consumes these outputs.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: After reset, every address register, every mask register and `rx_buf` read as zero, and `addr_match`, `gc_match`, `match_idx` and `rw_bit` are all zero.
- R2: SDA falling while SCL is high is a START, and it is also a repeated START when it occurs inside a transfer. Each START makes the next eight SCL rising edges form an address byte, sampled MSB first.
- R3: In a transfer, the ninth SCL rising edge of every byte (eight data bits, then the acknowledge bit) loads the eight data bits into `rx_buf`, with the first bit received in bit 7.
- R4: Slot i hits when the address bits 7:1 of the received byte equal bits 7:1 of address register i at every position where mask bit of register i is 0. A mask bit of 1 makes that address bit a don't-care.
- R5: When several slots hit, `match_idx` reports the lowest-numbered one.
- R6: A received 7-bit address of 0000000 is a general call. It is recognised only when bit 0 of at least one address register is set, and masks play no part in this case. On recognition `gc_match` is 1 and `match_idx` is the lowest slot whose bit 0 is set.
- R7: A slot whose address field (bits 7:1) is zero never produces a match on a nonzero received address, whatever its mask.
- R8: Only the first byte after a START or repeated START is compared. Later bytes of the same transfer never raise `addr_match`.
- R9: A STOP (SDA rising while SCL is high), or a START, that arrives part-way through a byte discards that byte. `rx_buf` keeps its value and the bit count restarts from zero.
- R10: At each address decision `addr_match` is high for exactly one clock cycle if a match occurred. At the same decision `rw_bit` takes the eighth received bit. On no match, `gc_match` and `match_idx` become 0. These outputs hold until the next decision.
- R11: When `cfg_we` is high on a clock edge, `cfg_wdata` is written to the register of slot `cfg_slot`. With `cfg_is_mask` = 0 this is the address register: address in bits 7:1, general-call enable in bit 0. With `cfg_is_mask` = 1 it is the mask register, which takes bits 7:1.
- R12: SCL edges seen while no transfer is open (before any START, or after a STOP) are ignored. They change neither `rx_buf` nor `addr_match`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw I2C clock line |
| sda_in | input | 1 | Raw I2C data line |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_mask | input | 1 | 0 selects an address register, 1 selects a mask register |
| cfg_slot | input | 2 | Slot number to write |
| cfg_wdata | input | 8 | Write data |
| addr_match | output | 1 | One-cycle pulse: address byte matched |
| match_idx | output | 2 | Lowest matching slot |
| gc_match | output | 1 | Last decision was a general call |
| rw_bit | output | 1 | Direction bit of the last address byte |
| rx_buf | output | 8 | Last completed received byte |

## Verification
A wrong bit counter shows up as a misaligned byte. After an aborted byte, the next address would be mis-framed. The result would be a missing pulse, a wrong `rw_bit`, or a corrupted `rx_buf` within one byte time, about nine SCL periods. A stale first-byte flag raises `addr_match` on a data byte of the same transfer. A fault in the masks, the priority order or the general-call handling appears as a wrong `match_idx` or `gc_match` at the very next address decision. The directed scenarios are arranged so that each of these faults changes a value the bench compares.

// File: rtl/i2c_rcg_pkg.sv
package i2c_rcg_pkg;

   // Target selector of the configuration write port.
   typedef enum logic {
      CFG_ADDR = 1'b0,
      CFG_MASK = 1'b1
   } cfg_tgt_e;

   // Defaults shared by the top module and its sub-blocks.
   localparam int DEF_NUM_SLOTS   = 4;
   localparam int DEF_ADDR_W      = 7;
   localparam int DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/i2c_rcg_line_cond.sv
// Synchronizes SCL/SDA and derives the rising-clock, START and STOP events.
module i2c_rcg_line_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_s,
   output logic scl_rise,
   output logic start_det,
   output logic stop_det
);
   // Index 1 is SCL, index 0 is SDA; one extra stage keeps the previous sample.
   localparam int CHAIN = SYNC_STAGES + 1;

   logic [CHAIN-1:0][1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;                 // idle bus is high on both lines
      end else begin
         chain_q[0] <= {scl_in, sda_in};
         for (int k = 1; k < CHAIN; k++) begin
            chain_q[k] <= chain_q[k-1];
         end
      end
   end

   logic scl_now, scl_prev, sda_prev;
   assign scl_now  = chain_q[SYNC_STAGES-1][1];
   assign sda_s    = chain_q[SYNC_STAGES-1][0];
   assign scl_prev = chain_q[SYNC_STAGES][1];
   assign sda_prev = chain_q[SYNC_STAGES][0];

   assign scl_rise  = scl_now & ~scl_prev;
   assign start_det = scl_now & scl_prev &  sda_prev & ~sda_s;
   assign stop_det  = scl_now & scl_prev & ~sda_prev &  sda_s;

endmodule

// File: rtl/i2c_rcg_framer.sv
// Bit counter, receive shift register, data buffer and address-byte strobe.
module i2c_rcg_framer #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              start_det,
   input  logic              stop_det,
   output logic              in_frame,
   output logic              addr_stb,
   output logic [BYTE_W-1:0] addr_byte,
   output logic [BYTE_W-1:0] rx_buf
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W);

   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic              first_byte;
   logic [BYTE_W-1:0] shifted;

   assign shifted = {shreg[BYTE_W-2:0], sda_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt    <= '0;
         shreg      <= '0;
         first_byte <= 1'b0;
         in_frame   <= 1'b0;
         addr_stb   <= 1'b0;
         addr_byte  <= '0;
         rx_buf     <= '0;
      end else begin
         addr_stb <= 1'b0;
         if (start_det) begin
            in_frame   <= 1'b1;
            first_byte <= 1'b1;
            bit_cnt    <= '0;
         end else if (stop_det) begin
            in_frame   <= 1'b0;
            first_byte <= 1'b0;
            bit_cnt    <= '0;
         end else if (scl_rise && in_frame) begin
            if (bit_cnt == ACK_SLOT) begin
               // acknowledge bit clocked: data bits move to the buffer
               rx_buf     <= shreg;
               bit_cnt    <= '0;
               first_byte <= 1'b0;
            end else begin
               shreg   <= shifted;
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == LAST_DATA && first_byte) begin
                  addr_stb  <= 1'b1;
                  addr_byte <= shifted;
               end
            end
         end
      end
   end

endmodule

// File: rtl/i2c_rcg_prio_enc.sv
// Lowest-index-wins priority encoder.
module i2c_rcg_prio_enc #(
   parameter int N = 4,
   localparam int W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] req,
   output logic         any,
   output logic [W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = W'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/i2c_rcg_addr_cmp.sv
// Parallel masked comparison of the received address against every slot.
module i2c_rcg_addr_cmp #(
   parameter int NUM_SLOTS = 4,
   parameter int ADDR_W    = 7,
   localparam int BYTE_W   = ADDR_W + 1,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic [ADDR_W-1:0]                 rx_addr,
   input  logic [NUM_SLOTS-1:0][BYTE_W-1:0]  adr_regs,
   input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]  msk_regs,
   output logic                              hit,
   output logic                              is_gc,
   output logic [SLOT_W-1:0]                 hit_idx
);
   logic [NUM_SLOTS-1:0] slot_hit;
   logic [NUM_SLOTS-1:0] slot_gc;
   logic [NUM_SLOTS-1:0] cand;

   genvar s;
   generate
      for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
         logic [ADDR_W-1:0] slot_adr;
         logic [ADDR_W-1:0] diff;
         assign slot_adr    = adr_regs[s][BYTE_W-1:1];
         assign diff        = (rx_addr ^ slot_adr) & ~msk_regs[s];
         assign slot_hit[s] = (slot_adr != '0) && (diff == '0);
         assign slot_gc[s]  = adr_regs[s][0];
      end
   endgenerate

   // the general-call address bypasses the masks entirely
   assign is_gc = (rx_addr == '0);
   assign cand  = is_gc ? slot_gc : slot_hit;

   i2c_rcg_prio_enc #(.N(NUM_SLOTS)) u_prio (
      .req (cand),
      .any (hit),
      .idx (hit_idx)
   );

endmodule

// File: rtl/i2c_addr_recognizer.sv
module i2c_addr_recognizer
   import i2c_rcg_pkg::*;
#(
   parameter int NUM_SLOTS   = DEF_NUM_SLOTS,
   parameter int ADDR_W      = DEF_ADDR_W,
   parameter int SYNC_STAGES = DEF_SYNC_STAGES,
   localparam int BYTE_W     = ADDR_W + 1,
   localparam int SLOT_W     = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic              cfg_we,
   input  logic              cfg_is_mask,
   input  logic [SLOT_W-1:0] cfg_slot,
   input  logic [BYTE_W-1:0] cfg_wdata,
   output logic              addr_match,
   output logic [SLOT_W-1:0] match_idx,
   output logic              gc_match,
   output logic              rw_bit,
   output logic [BYTE_W-1:0] rx_buf
);
   // ---------------- elaboration-time parameter checks ----------------
   generate
      if (NUM_SLOTS < 2) begin : g_bad_slots
         $error("NUM_SLOTS must be at least 2");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   // ---------------- configuration registers ----------------
   logic [NUM_SLOTS-1:0][BYTE_W-1:0] adr_q;
   logic [NUM_SLOTS-1:0][ADDR_W-1:0] msk_q;
   cfg_tgt_e cfg_tgt;

   assign cfg_tgt = cfg_tgt_e'(cfg_is_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adr_q <= '0;
         msk_q <= '0;
      end else if (cfg_we && (int'(cfg_slot) < NUM_SLOTS)) begin
         if (cfg_tgt == CFG_MASK) msk_q[cfg_slot] <= cfg_wdata[BYTE_W-1:1];
         else                     adr_q[cfg_slot] <= cfg_wdata;
      end
   end

   // ---------------- bus front end and framing ----------------
   logic sda_s, scl_rise, start_det, stop_det;

   i2c_rcg_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   logic              fr_in_frame;
   logic              fr_addr_stb;
   logic [BYTE_W-1:0] fr_addr_byte;

   i2c_rcg_framer #(.BYTE_W(BYTE_W)) u_frm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .start_det (start_det),
      .stop_det  (stop_det),
      .in_frame  (fr_in_frame),
      .addr_stb  (fr_addr_stb),
      .addr_byte (fr_addr_byte),
      .rx_buf    (rx_buf)
   );

   // ---------------- address decision ----------------
   logic              cmp_hit, cmp_gc;
   logic [SLOT_W-1:0] cmp_idx;

   i2c_rcg_addr_cmp #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_cmp (
      .rx_addr  (fr_addr_byte[BYTE_W-1:1]),
      .adr_regs (adr_q),
      .msk_regs (msk_q),
      .hit      (cmp_hit),
      .is_gc    (cmp_gc),
      .hit_idx  (cmp_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_match <= 1'b0;
         match_idx  <= '0;
         gc_match   <= 1'b0;
         rw_bit     <= 1'b0;
      end else if (fr_addr_stb) begin
         addr_match <= cmp_hit;
         gc_match   <= cmp_hit & cmp_gc;
         match_idx  <= cmp_hit ? cmp_idx : '0;
         rw_bit     <= fr_addr_byte[0];
      end else begin
         addr_match <= 1'b0;
      end
   end

endmodule

// File: rtl/i2c_rcg_checker.sv
module i2c_rcg_checker #(
   parameter int NUM_SLOTS = 4,
   parameter int ADDR_W    = 7,
   localparam int BYTE_W   = ADDR_W + 1,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             addr_match,
   input logic                             gc_match,
   input logic [SLOT_W-1:0]                match_idx,
   input logic                             rw_bit,
   input logic                             fr_in_frame,
   input logic [BYTE_W-1:0]                fr_addr_byte,
   input logic [NUM_SLOTS-1:0][BYTE_W-1:0] adr_q,
   input logic [NUM_SLOTS-1:0][ADDR_W-1:0] msk_q
);
   // registers as they stood when the decision was taken
   logic [NUM_SLOTS-1:0][BYTE_W-1:0] adr_d;
   logic [NUM_SLOTS-1:0][ADDR_W-1:0] msk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adr_d <= '0;
         msk_d <= '0;
      end else begin
         adr_d <= adr_q;
         msk_d <= msk_q;
      end
   end

   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      addr_match |=> !addr_match);

   a_r10_rw_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
      addr_match |-> (rw_bit == fr_addr_byte[0]));

   a_r4_masked_hit_agrees: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_match && !gc_match) |->
         (((fr_addr_byte[BYTE_W-1:1] ^ adr_d[match_idx][BYTE_W-1:1])
           & ~msk_d[match_idx]) == '0));

   a_r7_zero_slot_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_match && !gc_match) |-> (adr_d[match_idx][BYTE_W-1:1] != '0));

   a_r6_gc_needs_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_match && gc_match) |-> (fr_addr_byte[BYTE_W-1:1] == '0));

   a_r6_gc_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_match && gc_match) |-> adr_d[match_idx][0]);

   a_r12_match_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
      addr_match |-> $past(fr_in_frame));

endmodule

bind i2c_addr_recognizer i2c_rcg_checker #(
   .NUM_SLOTS (NUM_SLOTS),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .addr_match   (addr_match),
   .gc_match     (gc_match),
   .match_idx    (match_idx),
   .rw_bit       (rw_bit),
   .fr_in_frame  (fr_in_frame),
   .fr_addr_byte (fr_addr_byte),
   .adr_q        (adr_q),
   .msk_q        (msk_q)
);

// File: tb/tb_i2c_addr_recognizer.sv
`timescale 1ns/1ps
module tb_i2c_addr_recognizer;

   localparam int Q = 6;   // system clocks per quarter of an SCL step

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_in = 1'b1;
   logic       sda_in = 1'b1;
   logic       cfg_we = 1'b0;
   logic       cfg_is_mask = 1'b0;
   logic [1:0] cfg_slot = '0;
   logic [7:0] cfg_wdata = '0;
   logic       addr_match;
   logic [1:0] match_idx;
   logic       gc_match;
   logic       rw_bit;
   logic [7:0] rx_buf;

   int n_cmp = 0;
   int n_bad = 0;
   int pulses = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   i2c_addr_recognizer dut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .cfg_we(cfg_we), .cfg_is_mask(cfg_is_mask), .cfg_slot(cfg_slot),
      .cfg_wdata(cfg_wdata), .addr_match(addr_match), .match_idx(match_idx),
      .gc_match(gc_match), .rw_bit(rw_bit), .rx_buf(rx_buf)
   );

   always @(negedge clk) if (rst_n && addr_match) pulses++;

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      repeat (Q) @(negedge clk);
   endtask

   task automatic set_slot(input int s, input logic [7:0] adr, input logic [6:0] msk);
      @(negedge clk);
      cfg_we = 1'b1; cfg_slot = 2'(s); cfg_is_mask = 1'b0; cfg_wdata = adr;
      @(negedge clk);
      cfg_is_mask = 1'b1; cfg_wdata = {msk, 1'b0};
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic bus_start();
      sda_in = 1'b1; step(); scl_in = 1'b1; step();
      sda_in = 1'b0; step(); scl_in = 1'b0; step();
   endtask

   task automatic bus_stop();
      sda_in = 1'b0; step(); scl_in = 1'b1; step();
      sda_in = 1'b1; step(); step();
   endtask

   task automatic bus_bit(input logic b);
      sda_in = b; step(); scl_in = 1'b1; step(); scl_in = 1'b0; step();
   endtask

   task automatic bus_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) bus_bit(b[i]);
      bus_bit(1'b0);   // acknowledge slot
   endtask

   task automatic xfer_addr(input logic [7:0] b);
      bus_start(); bus_byte(b); bus_stop();
   endtask

   task automatic clear_slots();
      for (int s = 0; s < 4; s++) set_slot(s, 8'h00, 7'h00);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk("R1 rx_buf",     rx_buf, 0);
      chk("R1 addr_match", addr_match, 0);
      chk("R1 gc_match",   gc_match, 0);
      chk("R1 match_idx",  match_idx, 0);
      chk("R1 rw_bit",     rw_bit, 0);
      // all registers zero: neither a plain address nor a general call matches
      begin
         int p0 = pulses;
         xfer_addr(8'h00);
         xfer_addr(8'h54);
         chk("R1 zero registers give no match", pulses - p0, 0);
      end
   endtask

   task automatic t_plain();
      int p0;
      clear_slots();
      set_slot(1, 8'h74, 7'h00);           // slot1 address 7'h3A
      p0 = pulses;
      xfer_addr(8'h75);                    // 7'h3A, read
      chk("R11 R4 plain hit pulse", pulses - p0, 1);
      chk("R4 plain hit idx", match_idx, 1);
      chk("R10 rw read",      rw_bit, 1);
      chk("R6 no gc on plain",gc_match, 0);
      chk("R3 R2 buffer holds address byte", rx_buf, 8'h75);
   endtask

   task automatic t_mask();
      int p0;
      set_slot(2, 8'h40, 7'h0F);           // 7'h20, low four bits don't-care
      p0 = pulses;
      xfer_addr(8'h56);                    // 7'h2B write
      chk("R4 masked hit pulse", pulses - p0, 1);
      chk("R4 masked hit idx",   match_idx, 2);
      chk("R10 rw write",        rw_bit, 0);
      p0 = pulses;
      xfer_addr(8'h61);                    // 7'h30: unmasked bit differs
      chk("R4 unmasked diff no pulse", pulses - p0, 0);
      chk("R10 idx cleared on miss",   match_idx, 0);
      chk("R10 rw updated on miss",    rw_bit, 1);
   endtask

   task automatic t_priority();
      int p0;
      set_slot(3, 8'h74, 7'h00);           // duplicate of slot1
      p0 = pulses;
      xfer_addr(8'h74);
      chk("R5 two hits pulse", pulses - p0, 1);
      chk("R5 lowest of 1,3",  match_idx, 1);
      set_slot(0, 8'h02, 7'h7F);           // slot0 nonzero, fully masked
      xfer_addr(8'h74);
      chk("R5 fully masked slot0 wins", match_idx, 0);
   endtask

   task automatic t_general_call();
      int p0;
      set_slot(2, 8'h41, 7'h0F);           // gc enabled only on slot2
      p0 = pulses;
      xfer_addr(8'h00);
      chk("R6 gc pulse", pulses - p0, 1);
      chk("R6 gc flag",  gc_match, 1);
      chk("R6 gc idx ignores masks", match_idx, 2);
      set_slot(2, 8'h40, 7'h0F);           // gc disabled everywhere
      p0 = pulses;
      xfer_addr(8'h01);
      chk("R6 gc disabled no pulse", pulses - p0, 0);
      chk("R6 gc flag cleared",      gc_match, 0);
      chk("R10 rw on gc miss",       rw_bit, 1);
   endtask

   task automatic t_zero_slot();
      int p0;
      for (int s = 0; s < 4; s++) set_slot(s, 8'h00, 7'h7F);
      p0 = pulses;
      xfer_addr(8'hAA);
      xfer_addr(8'h00);
      chk("R7 zero slots never match", pulses - p0, 0);
   endtask

   task automatic t_later_bytes();
      int p0;
      clear_slots();
      set_slot(1, 8'h74, 7'h00);
      p0 = pulses;
      bus_start(); bus_byte(8'h74); bus_byte(8'h74);
      chk("R3 data byte buffered", rx_buf, 8'h74);
      bus_byte(8'hA5); bus_stop();
      chk("R8 only first byte compared", pulses - p0, 1);
      chk("R3 last data byte buffered",  rx_buf, 8'hA5);
   endtask

   task automatic t_repeated_start();
      int p0;
      p0 = pulses;
      bus_start(); bus_byte(8'h74); bus_start(); bus_byte(8'h75); bus_stop();
      chk("R2 repeated start decides again", pulses - p0, 2);
      chk("R2 rw after repeated start",      rw_bit, 1);
      chk("R2 idx after repeated start",     match_idx, 1);
   endtask

   task automatic t_abort();
      int p0;
      bus_start(); bus_byte(8'h3C);
      chk("R3 address byte buffered", rx_buf, 8'h3C);
      bus_start();
      for (int i = 0; i < 4; i++) bus_bit(1'b1);
      bus_stop();
      chk("R9 stop mid-byte keeps buffer", rx_buf, 8'h3C);
      p0 = pulses;
      bus_start();
      for (int i = 0; i < 5; i++) bus_bit(1'b1);
      bus_start(); bus_byte(8'h74); bus_stop();
      chk("R9 restart realigns count", pulses - p0, 1);
      chk("R9 realigned rw",          rw_bit, 0);
      chk("R9 start mid-byte buffer", rx_buf, 8'h74);
   endtask

   task automatic t_idle();
      int p0;
      p0 = pulses;
      for (int i = 0; i < 9; i++) bus_bit(1'b1);
      bus_byte(8'h74);
      sda_in = 1'b1; step();
      chk("R12 idle clocks no match",    pulses - p0, 0);
      chk("R12 idle clocks keep buffer", rx_buf, 8'h74);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_plain();
      t_mask();
      t_priority();
      t_general_call();
      t_zero_slot();
      t_later_bytes();
      t_repeated_start();
      t_abort();
      t_idle();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule